// File: doc/BRIEF.md
# Programmable Internal Trigger Generator

This block produces trigger strobes from three internal sources and merges them onto one registered output. The random source draws a fresh pseudo-random word on every clock cycle. It fires when that word is below a programmable rate threshold. As a result, the average trigger frequency is the clock frequency scaled by the rate divided by the full-scale value. The periodic source counts clock cycles against a programmable interval and fires once per interval while it is enabled. The software source fires once for each force write that carries a 1.

Control reaches the block as write strobes with their data values. A resync write realigns the periodic counter to the moment of the write, so several generators can be brought into phase. The pulses of all sources are ORed together and pass through one output register. A trigger therefore appears exactly one cycle after the cycle in which it was requested.

Top module: `inttrig_gen`

## Requirements
- R1: After synchronous reset, `trig_out` is 0, the rate register, the periodic enable and the interval register are all 0, and no trigger is produced until something is written.
- R2: While the rate register holds 0, the random source never requests a trigger.
- R3: On every cycle the random source compares a fresh word from a never-zero maximal-length shift register with the rate register and requests a trigger when the word is strictly less than the rate. All-ones therefore fires on nearly every cycle, 0x80000000 on about half of the cycles and 0x40000000 on about a quarter of them.
- R4: A force write (`force_we`=1) with `force_wdata`=1 gives exactly one trigger, and a force write with `force_wdata`=0 gives none.
- R5: With the enable at 1 and an interval I of at least 1, the periodic source gives a trigger every I cycles. The first trigger shows on `trig_out` I cycles after the clock edge that restarted the counter.
- R6: The periodic counter restarts on any interval write and on an enable write that takes the enable from 0 to 1.
- R7: A resync write with `resync_wdata`=1 restarts the periodic counter. A restart request suppresses any periodic request in the same cycle.
- R8: An interval of 0, or an enable of 0, stops all periodic triggers.
- R9: When sources request in the same cycle, `trig_out` is high for that one cycle only, and it is low on the next cycle unless a new request occurs.
- R10: Every request shows on `trig_out` one clock edge after the cycle in which it was made. A request made in the cycle just before an edge is therefore visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rate_we | input | 1 | Write strobe for the random rate register |
| rate_wdata | input | RATE_W | Random rate value, per-cycle probability rate / 2^RATE_W |
| cyc_en_we | input | 1 | Write strobe for the periodic enable |
| cyc_en_wdata | input | 1 | Periodic enable value |
| ivl_we | input | 1 | Write strobe for the periodic interval |
| ivl_wdata | input | IVL_W | Periodic interval in clock cycles, 0 means disabled |
| force_we | input | 1 | Write strobe for the software force control |
| force_wdata | input | 1 | Force value; 1 requests a single trigger |
| resync_we | input | 1 | Write strobe for the resync control |
| resync_wdata | input | 1 | Resync value; 1 restarts the periodic counter |
| trig_out | output | 1 | One-cycle trigger strobe, registered |

## Verification
The checker assumes that reset is held for at least one rising edge before any property is relied on, and that every write strobe and data input is at a known level at each edge. The properties do not depend on how long a strobe is held, so back-to-back writes are legal. The bench holds reset for several cycles and changes every input only on falling edges, so it never drives an unknown value. Each strobe it raises lasts exactly one rising edge, which keeps every pulse a single-cycle request as the force and resync controls expect.

// File: rtl/inttrig_pkg.sv
package inttrig_pkg;

   // Feedback mask for a maximal-length shift register of width w.
   // Bit (t-1) is set for each tap t of the polynomial; 0 = unsupported.
   function automatic logic [63:0] lfsr_taps(input int w);
      case (w)
         8:       return 64'h0000_0000_0000_00B8;
         16:      return 64'h0000_0000_0000_D008;
         24:      return 64'h0000_0000_00E1_0000;
         32:      return 64'h0000_0000_8020_0003;
         default: return 64'h0;
      endcase
   endfunction

endpackage

// File: rtl/inttrig_lfsr.sv
module inttrig_lfsr #(
   parameter int             W      = 32,
   parameter logic [W-1:0]   SEED   = 1,
   parameter bit             GALOIS = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   output logic [W-1:0] state
);
   import inttrig_pkg::*;

   localparam logic [63:0]  TAPS64 = lfsr_taps(W);
   localparam logic [W-1:0] TAPS   = TAPS64[W-1:0];

   if (TAPS == '0) begin : g_bad_width
      $error("inttrig_lfsr: width %0d has no tap set", W);
   end
   if (SEED == '0) begin : g_bad_seed
      $error("inttrig_lfsr: seed must be nonzero");
   end

   logic [W-1:0] nxt;

   if (GALOIS) begin : g_galois
      always_comb begin
         nxt = {1'b0, state[W-1:1]};
         if (state[0]) nxt = nxt ^ TAPS;
      end
   end else begin : g_fibonacci
      always_comb nxt = {state[W-2:0], ^(state & TAPS)};
   end

   always_ff @(posedge clk) begin
      if (rst) state <= SEED;
      else     state <= nxt;
   end
endmodule

// File: rtl/inttrig_periodic.sv
module inttrig_periodic #(
   parameter int IVL_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en_we,
   input  logic             en_wdata,
   input  logic             ivl_we,
   input  logic [IVL_W-1:0] ivl_wdata,
   input  logic             resync,
   output logic             armed,
   output logic             per_req
);
   if (IVL_W < 2) begin : g_bad_ivl
      $error("inttrig_periodic: IVL_W must be at least 2");
   end

   localparam logic [IVL_W-1:0] ONE = IVL_W'(1);

   logic             en_q;
   logic [IVL_W-1:0] ivl_q;
   logic [IVL_W-1:0] cnt_q;
   logic             restart;

   assign restart = (en_we && en_wdata && !en_q) || ivl_we || resync;
   assign armed   = en_q && (ivl_q != '0);
   assign per_req = armed && !restart && (cnt_q == ivl_q - ONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         en_q  <= 1'b0;
         ivl_q <= '0;
         cnt_q <= '0;
      end else begin
         if (en_we)  en_q  <= en_wdata;
         if (ivl_we) ivl_q <= ivl_wdata;
         if (restart || !armed || per_req) cnt_q <= '0;
         else                              cnt_q <= cnt_q + ONE;
      end
   end
endmodule

// File: rtl/inttrig_gen.sv
module inttrig_gen #(
   parameter int                RATE_W      = 32,
   parameter int                IVL_W       = 32,
   parameter logic [RATE_W-1:0] LFSR_SEED   = 1,
   parameter bit                LFSR_GALOIS = 1'b0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              rate_we,
   input  logic [RATE_W-1:0] rate_wdata,
   input  logic              cyc_en_we,
   input  logic              cyc_en_wdata,
   input  logic              ivl_we,
   input  logic [IVL_W-1:0]  ivl_wdata,
   input  logic              force_we,
   input  logic              force_wdata,
   input  logic              resync_we,
   input  logic              resync_wdata,
   output logic              trig_out
);
   logic [RATE_W-1:0] rate_q;
   logic [RATE_W-1:0] lfsr_q;
   logic              rnd_req;
   logic              per_req;
   logic              armed;
   logic              force_req;
   logic              resync_req;

   assign force_req  = force_we && force_wdata;
   assign resync_req = resync_we && resync_wdata;

   always_ff @(posedge clk) begin
      if (rst)          rate_q <= '0;
      else if (rate_we) rate_q <= rate_wdata;
   end

   inttrig_lfsr #(
      .W      (RATE_W),
      .SEED   (LFSR_SEED),
      .GALOIS (LFSR_GALOIS)
   ) u_lfsr (
      .clk   (clk),
      .rst   (rst),
      .state (lfsr_q)
   );

   assign rnd_req = (lfsr_q < rate_q);

   inttrig_periodic #(
      .IVL_W (IVL_W)
   ) u_periodic (
      .clk       (clk),
      .rst       (rst),
      .en_we     (cyc_en_we),
      .en_wdata  (cyc_en_wdata),
      .ivl_we    (ivl_we),
      .ivl_wdata (ivl_wdata),
      .resync    (resync_req),
      .armed     (armed),
      .per_req   (per_req)
   );

   always_ff @(posedge clk) begin
      if (rst) trig_out <= 1'b0;
      else     trig_out <= rnd_req || per_req || force_req;
   end
endmodule

// File: rtl/inttrig_chk.sv
module inttrig_chk #(
   parameter int RATE_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic [RATE_W-1:0] rate_q,
   input logic [RATE_W-1:0] lfsr_q,
   input logic              rnd_req,
   input logic              per_req,
   input logic              armed,
   input logic              force_req,
   input logic              resync_req,
   input logic              trig_out
);
   p_reset_quiet_r1: assert property (@(posedge clk)
      rst |=> !trig_out);

   p_zero_rate_r2: assert property (@(posedge clk) disable iff (rst)
      (rate_q == '0) |-> !rnd_req);

   p_lfsr_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
      lfsr_q != '0);

   p_force_r4: assert property (@(posedge clk) disable iff (rst)
      force_req |=> trig_out);

   p_disarmed_r8: assert property (@(posedge clk) disable iff (rst)
      !armed |-> !per_req);

   p_resync_gap_r7: assert property (@(posedge clk) disable iff (rst)
      resync_req |-> !per_req);

   p_periodic_latency_r10: assert property (@(posedge clk) disable iff (rst)
      per_req |=> trig_out);

   p_no_spurious_r9: assert property (@(posedge clk) disable iff (rst)
      (!rnd_req && !per_req && !force_req) |=> !trig_out);
endmodule

bind inttrig_gen inttrig_chk #(.RATE_W(RATE_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .rate_q     (rate_q),
   .lfsr_q     (lfsr_q),
   .rnd_req    (rnd_req),
   .per_req    (per_req),
   .armed      (armed),
   .force_req  (force_req),
   .resync_req (resync_req),
   .trig_out   (trig_out)
);

// File: tb/inttrig_gen_bench.sv
module inttrig_gen_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        rate_we = 1'b0;
   logic [31:0] rate_wdata = '0;
   logic        cyc_en_we = 1'b0;
   logic        cyc_en_wdata = 1'b0;
   logic        ivl_we = 1'b0;
   logic [31:0] ivl_wdata = '0;
   logic        force_we = 1'b0;
   logic        force_wdata = 1'b0;
   logic        resync_we = 1'b0;
   logic        resync_wdata = 1'b0;
   logic        trig_out;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   inttrig_gen u_inttrig_gen (
      .clk(clk), .rst(rst),
      .rate_we(rate_we), .rate_wdata(rate_wdata),
      .cyc_en_we(cyc_en_we), .cyc_en_wdata(cyc_en_wdata),
      .ivl_we(ivl_we), .ivl_wdata(ivl_wdata),
      .force_we(force_we), .force_wdata(force_wdata),
      .resync_we(resync_we), .resync_wdata(resync_wdata),
      .trig_out(trig_out)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // advance to the next falling edge (one rising edge passes)
   task automatic tick();
      @(negedge clk);
   endtask

   task automatic clear_strobes();
      rate_we = 0; cyc_en_we = 0; ivl_we = 0; force_we = 0; resync_we = 0;
   endtask

   task automatic wr_rate(input logic [31:0] v);
      rate_we = 1; rate_wdata = v; tick(); clear_strobes();
   endtask

   task automatic wr_en(input logic v);
      cyc_en_we = 1; cyc_en_wdata = v; tick(); clear_strobes();
   endtask

   task automatic wr_ivl(input logic [31:0] v);
      ivl_we = 1; ivl_wdata = v; tick(); clear_strobes();
   endtask

   // count triggers over n cycles
   task automatic count_trigs(input int n, output int c);
      c = 0;
      for (int i = 0; i < n; i++) begin
         tick();
         if (trig_out) c++;
      end
   endtask

   // from a restart edge (current sample is k=0), expect a trigger every per cycles
   task automatic expect_period(input int per, input int n, input string tag);
      int errs = 0;
      for (int k = 1; k <= n; k++) begin
         tick();
         if (trig_out !== ((k % per) == 0)) errs++;
      end
      chk(errs == 0, tag, errs, 0);
   endtask

   initial begin
      int c;
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int c;
      repeat (5) tick();
      rst = 0;
      // R1: reset state, quiet
      chk(trig_out == 1'b0, "R1 reset output", int'(trig_out), 0);
      count_trigs(64, c);
      chk(c == 0, "R1 quiet after reset", c, 0);

      // R3: full-scale rate
      wr_rate(32'hFFFF_FFFF); tick();
      count_trigs(500, c);
      chk(c >= 499, "R3 full rate", c, 500);
      // R3: half rate
      wr_rate(32'h8000_0000); tick();
      count_trigs(4096, c);
      chk(c >= 1700 && c <= 2400, "R3 half rate", c, 2048);
      // R3: quarter rate
      wr_rate(32'h4000_0000); tick();
      count_trigs(4096, c);
      chk(c >= 750 && c <= 1300, "R3 quarter rate", c, 1024);
      // R2: back to zero
      wr_rate(32'h0); tick();
      count_trigs(1000, c);
      chk(c == 0, "R2 zero rate", c, 0);

      // R4/R10: force
      force_we = 1; force_wdata = 1; tick(); clear_strobes();
      chk(trig_out == 1'b1, "R4 R10 force latency", int'(trig_out), 1);
      tick();
      chk(trig_out == 1'b0, "R4 single force pulse", int'(trig_out), 0);
      force_we = 1; force_wdata = 0; tick(); clear_strobes();
      chk(trig_out == 1'b0, "R4 force write of 0", int'(trig_out), 0);
      count_trigs(8, c);
      chk(c == 0, "R4 no trigger after 0 write", c, 0);

      // R5: sweep intervals 1..12
      for (int per = 1; per <= 12; per++) begin
         cyc_en_we = 1; cyc_en_wdata = 1; ivl_we = 1; ivl_wdata = per;
         tick(); clear_strobes();
         chk(trig_out == 1'b0, "R5 no trigger at restart edge", int'(trig_out), 0);
         expect_period(per, 3 * per + 12, $sformatf("R5 interval %0d", per));
         wr_en(0); tick();
         count_trigs(10, c);
         chk(c == 0, "R8 disabled periodic", c, 0);
      end

      // R6: interval rewrite restarts
      wr_ivl(6);
      wr_en(1);
      repeat (3) tick();
      wr_ivl(6);
      expect_period(6, 20, "R6 interval rewrite restart");
      // R6: enable rising restarts (interval kept)
      wr_en(0); tick();
      wr_en(1);
      expect_period(6, 20, "R6 enable rising restart");

      // R7: resync restarts
      repeat (2) tick();
      resync_we = 1; resync_wdata = 1; tick(); clear_strobes();
      expect_period(6, 20, "R7 resync restart");
      resync_we = 1; resync_wdata = 0; tick(); clear_strobes();
      // a resync write of 0 must not disturb the phase: 21 + 1 cycles after last restart
      // last restart at k=0 of previous window; now at k=21
      begin
         int errs = 0;
         for (int k = 22; k <= 40; k++) begin
            tick();
            if (trig_out !== ((k % 6) == 0)) errs++;
         end
         chk(errs == 0, "R7 resync write of 0 ignored", errs, 0);
      end

      // R9: periodic and force coincide
      wr_ivl(4);
      repeat (3) tick();
      force_we = 1; force_wdata = 1; tick(); clear_strobes();
      chk(trig_out == 1'b1, "R9 coincident trigger", int'(trig_out), 1);
      tick();
      chk(trig_out == 1'b0, "R9 single cycle after merge", int'(trig_out), 0);
      repeat (2) tick();
      chk(trig_out == 1'b0, "R9 no extra pulse", int'(trig_out), 0);
      tick();
      chk(trig_out == 1'b1, "R9 period kept after merge", int'(trig_out), 1);

      // R8: interval zero while enabled
      wr_ivl(0); tick();
      count_trigs(40, c);
      chk(c == 0, "R8 zero interval", c, 0);

      // R1: reset clears programmed state
      wr_rate(32'hFFFF_FFFF);
      wr_ivl(3);
      rst = 1; tick(); tick(); rst = 0;
      chk(trig_out == 1'b0, "R1 reset output after use", int'(trig_out), 0);
      count_trigs(50, c);
      chk(c == 0, "R1 registers cleared by reset", c, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule